// File: doc/BRIEF.md
# Idle Cell Tally with Byte-Window Readout

This block counts idle (empty) cells reported by a receive path and lets a host read the result over a narrow register bus. A one-cycle event strobe bumps a live counter. A sample command copies the live count into a holding register and restarts the live counter in the same cycle, so each held value covers exactly one sampling period. A separate clear command restarts the live counter without disturbing the held value.

The host reads the held value through one byte-wide window. An internal phase pointer picks the low byte, then the middle byte, then the top nibble, and it advances by itself on every read strobe. The host therefore reads the full value with three reads in a row. If the live counter wraps past all ones, a sticky overflow flag is set. That flag, gated by an enable input, drives an interrupt.

Top module: `idle_cell_tally`

## Requirements
- R1: The live counter (CNT_W = 20 bits) increases by one on every clock edge where `cell_evt` is high and neither `snap_cmd` nor `zero_cmd` is high.
- R2: On `snap_cmd` the holding register takes the live count as it was before that edge, and the live counter restarts. It restarts at 1 if `cell_evt` is also high in that cycle and at 0 otherwise.
- R3: The holding register does not change on any edge without `snap_cmd`, whatever happens on `cell_evt`, `zero_cmd` or `rd_stb`.
- R4: `zero_cmd` sets the live counter to 0 and leaves the holding register unchanged. It takes priority over a coincident `cell_evt`.
- R5: `rd_data` is a combinational view of the holding register, selected by `rd_phase`. Phase 0 shows bits 7:0, phase 1 shows bits 15:8, and phase 2 shows bits 19:16 in its low nibble with zeros in bits 7:4.
- R6: `rd_phase` is 0 after reset and holds when `rd_stb` is low. Each edge with `rd_stb` high moves it 0→1→2→0. It never shows the value 3, and an unused phase value returns to 0 on the next read with `rd_data` at zero.
- R7: A `cell_evt` arriving while the live counter is all ones, with no sample or clear in the same cycle, sets `ovf_flag` and wraps the live counter to 0.
- R8: `ovf_flag` is 0 after reset and stays set until an edge with `ovf_clr` high and no new overflow. A new overflow in the same cycle wins over the clear.
- R9: `irq` is high exactly when `ovf_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_evt | input | 1 | One-cycle strobe per idle cell received |
| snap_cmd | input | 1 | Copy the live count into the holding register and restart the count |
| zero_cmd | input | 1 | Restart the live count only |
| rd_stb | input | 1 | Host read of the window; advances the phase |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Selected byte of the holding register |
| rd_phase | output | 2 | Current window phase |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
The counting path is tried with short bursts of a few cells, a long unbroken burst whose three bytes all differ (0x10203), a cell that coincides with a sample, and a cell that coincides with a clear. The distinct bytes show whether the windows are swapped or misaligned. The coincident cases show whether the boundary cell is dropped, counted twice, or counted in the wrong period. Reads are also spread out with idle gaps, which separates an advance driven by the read strobe from one driven by time. The wrap is tried on a narrow instance, where it can be reached quickly, and then the remainder count and the flag/enable combinations are checked.

// File: rtl/idle_cell_tally.sv
module idle_cell_tally #(
  parameter int CNT_W = 20,
  parameter int BUS_W = 8
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             cell_evt,
  input  logic                                             snap_cmd,
  input  logic                                             zero_cmd,
  input  logic                                             rd_stb,
  input  logic                                             ovf_clr,
  input  logic                                             irq_en,
  output logic [BUS_W-1:0]                                 rd_data,
  output logic [$clog2(((CNT_W + BUS_W - 1) / BUS_W) + 1)-1:0] rd_phase,
  output logic                                             ovf_flag,
  output logic                                             irq
);

  localparam int NWIN  = (CNT_W + BUS_W - 1) / BUS_W;
  localparam int PH_W  = $clog2(NWIN + 1);
  localparam int PAD_W = NWIN * BUS_W;
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] live;
  logic [CNT_W-1:0] held;
  logic [PAD_W-1:0] held_pad;
  logic             wrap_hit;
  int unsigned      win_idx;

  assign wrap_hit = cell_evt && !snap_cmd && !zero_cmd && (live == ALL_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live <= '0;
    else if (zero_cmd)  live <= '0;
    else if (snap_cmd)  live <= cell_evt ? CNT_W'(1) : '0;
    else if (cell_evt)  live <= live + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held <= '0;
    else if (snap_cmd) held <= live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap_hit) ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_phase <= '0;
    else if (rd_stb) rd_phase <= (rd_phase >= PH_W'(NWIN - 1)) ? '0 : rd_phase + PH_W'(1);
  end

  assign held_pad = PAD_W'(held);
  assign win_idx  = 32'(rd_phase);
  assign rd_data  = (win_idx < NWIN) ? BUS_W'(held_pad >> (win_idx * BUS_W)) : '0;
  assign irq      = ovf_flag & irq_en;

  AST_HOLD_ONLY_ON_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cmd |=> $stable(held)); // R3

  AST_SNAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cmd && !zero_cmd && !cell_evt) |=> (live == '0)); // R2

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> (live == '0)); // R4

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_evt && !snap_cmd && !zero_cmd && live == ALL_ONES) |=> (ovf_flag && live == '0)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_phase)); // R6

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_phase) < NWIN); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && irq_en)); // R9

endmodule

// File: tb/idle_cell_tally_bench.sv
module idle_cell_tally_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cell_evt = 0, snap_cmd = 0, zero_cmd = 0, rd_stb = 0, ovf_clr = 0, irq_en = 0;
  logic [7:0] rd_data;
  logic [1:0] rd_phase;
  logic       ovf_flag, irq;

  logic       s_cell = 0, s_snap = 0, s_rd = 0, s_clr = 0, s_en = 0;
  logic [7:0] s_data;
  logic [1:0] s_phase;
  logic       s_ovf, s_irq;

  idle_cell_tally u_idle_cell_tally (
    .clk(clk), .rst_n(rst_n), .cell_evt(cell_evt), .snap_cmd(snap_cmd), .zero_cmd(zero_cmd),
    .rd_stb(rd_stb), .ovf_clr(ovf_clr), .irq_en(irq_en), .rd_data(rd_data),
    .rd_phase(rd_phase), .ovf_flag(ovf_flag), .irq(irq));

  idle_cell_tally #(.CNT_W(10), .BUS_W(8)) u_idle_cell_tally_small (
    .clk(clk), .rst_n(rst_n), .cell_evt(s_cell), .snap_cmd(s_snap), .zero_cmd(1'b0),
    .rd_stb(s_rd), .ovf_clr(s_clr), .irq_en(s_en), .rd_data(s_data),
    .rd_phase(s_phase), .ovf_flag(s_ovf), .irq(s_irq));

  int checks = 0;
  int fails = 0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic rd3(input int v, input string tag);
    rd(v & 8'hff, tag);
    rd((v >> 8) & 8'hff, tag);
    rd((v >> 16) & 8'h0f, tag);
  endtask

  task automatic cells(input int n);
    @(negedge clk);
    cell_evt = 1;
    repeat (n) @(negedge clk);
    cell_evt = 0;
  endtask

  task automatic snap();
    @(negedge clk);
    snap_cmd = 1;
    @(negedge clk);
    snap_cmd = 0;
  endtask

  always @(negedge clk) begin
    #2;
    if (rd_stb) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 actual=%0h expected=none (unexpected read)", rd_data);
      end else begin
        check(int'(rd_data), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(rd_data, 0, "R5 reset data");
    check(rd_phase, 0, "R6 reset phase");
    check(ovf_flag, 0, "R8 reset flag");
    check(irq, 0, "R9 reset irq");

    cells(5); snap();
    rd3(5, "R1 R2 R5 five cells");
    #2; check(rd_phase, 0, "R6 phase wraps after three reads");

    cells(7);
    rd3(5, "R3 hold unchanged while counting");
    snap();
    rd(7, "R1 seven cells");
    #2; check(rd_phase, 1, "R6 phase after one read");
    repeat (3) @(negedge clk);
    #2; check(rd_phase, 1, "R6 phase holds without read");
    rd(0, "R5 mid byte"); rd(0, "R5 top nibble");
    #2; check(rd_phase, 0, "R6 phase back to zero");

    @(negedge clk); cell_evt = 1;
    repeat (3) @(negedge clk);
    snap_cmd = 1;
    @(negedge clk); snap_cmd = 0; cell_evt = 0;
    rd3(3, "R2 snapshot excludes coincident cell");
    snap();
    rd3(1, "R2 coincident cell counted in new period");

    cells(4);
    @(negedge clk); zero_cmd = 1;
    @(negedge clk); zero_cmd = 0;
    rd3(1, "R4 clear keeps hold");
    @(negedge clk); zero_cmd = 1; cell_evt = 1;
    @(negedge clk); zero_cmd = 0; cell_evt = 0;
    snap();
    rd3(0, "R4 clear beats coincident cell");

    cells(32'h10203); snap();
    rd3(32'h10203, "R5 distinct bytes");

    @(negedge clk); s_cell = 1;
    repeat (1023) @(negedge clk);
    s_cell = 0; #2;
    check(s_ovf, 0, "R7 no flag at all ones");
    @(negedge clk); s_cell = 1;
    @(negedge clk); s_cell = 0; #2;
    check(s_ovf, 1, "R7 flag on wrap");
    check(s_irq, 0, "R9 irq masked");
    @(negedge clk); s_en = 1; #2;
    check(s_irq, 1, "R9 irq enabled");
    @(negedge clk); s_cell = 1;
    repeat (2) @(negedge clk);
    s_cell = 0; s_snap = 1;
    @(negedge clk); s_snap = 0;
    @(negedge clk); s_rd = 1; #2;
    check(s_data, 2, "R7 count resumes from zero");
    @(negedge clk); s_rd = 0;
    repeat (5) @(negedge clk);
    #2; check(s_ovf, 1, "R8 flag sticky");
    @(negedge clk); s_clr = 1;
    @(negedge clk); s_clr = 0; #2;
    check(s_ovf, 0, "R8 write-one clears");
    check(s_irq, 0, "R9 irq drops with flag");

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 actual=%0d expected=0 pending reads", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule